// File: doc/BRIEF.md
# Transmit Character Down-Counter

This block counts the characters of one outgoing frame for a serial transmitter that is fed by DMA or by a host. Software writes the length of the next frame into a 16-bit limit register, which it can also read back. On each frame start the counter takes its value from that register. After that it counts down by one for every character written into the transmit FIFO. The character that takes the count from one to zero is marked as the end of the message. The counter then stops and raises a frame-complete indication. That indication lets the transmit-start hold-off release before the FIFO is full.

A limit of zero turns the counter off. A frame started with a zero limit leaves the counter idle, and character writes do not touch it. The counter only reloads on a frame start, so software can write the length of the following frame while the current one is still being counted.

Top module: `tx_char_counter`

## Requirements
- R1: After reset, `count`, `limitQ`, `active`, `frameComplete` and `lastChar` are all zero.
- R2: A cycle with `limitWrEn` high puts `limitWrData` on `limitQ` from the next cycle on. It does not change `count`, `active` or `frameComplete`.
- R3: When `frameStart` is high and the limit register is nonzero, the next cycle shows `count` equal to the limit value held before that edge, with `active` high and `frameComplete` low. A limit written in the same cycle is used by the next frame, not this one.
- R4: When `frameStart` is high and the limit register is zero, the next cycle shows `count` zero and `active` and `frameComplete` low. `charWr` then changes nothing until a frame starts with a nonzero limit.
- R5: A `charWr` while `active` is high and `frameStart` is low lowers `count` by exactly one at the next edge, whatever idle gaps lie between the characters.
- R6: `lastChar` is high, in the same cycle, exactly when `charWr` is high, `active` is high, `frameStart` is low and `count` is 1.
- R7: After the write flagged by `lastChar`, `active` is low and `count` is zero. Further `charWr` pulses leave `count` at zero, with no wrap.
- R8: If `frameStart` and `charWr` are high in the same cycle, the reload wins and that character is not counted.
- R9: `frameComplete` goes high at the edge after `lastChar`. It stays high until the next `frameStart`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| limitWrEn | input | 1 | Write strobe for the limit register |
| limitWrData | input | W | Frame length to store (0 turns counting off) |
| frameStart | input | 1 | Start of a new frame; reloads the counter |
| charWr | input | 1 | One character written into the transmit FIFO |
| limitQ | output | W | Readback of the limit register |
| count | output | W | Current remaining character count |
| active | output | 1 | Counter loaded and still counting |
| lastChar | output | 1 | The present character write is the frame's last |
| frameComplete | output | 1 | Whole frame has been written into the FIFO |

## Verification
The hardest condition to reach from the ports is the top of the count range. A frame of 65535 characters is the only way to show that the full-width value loads and counts down to zero without a fault in the upper bits. The bench runs one such frame, one character per cycle. Around it, the bench sweeps every length from 1 to 40 under several gap patterns and writes a new limit in the middle of a frame. It also drives `frameStart` in the same cycle as `charWr` and `limitWrEn`. At every cycle a bench-side arithmetic model gives the expected state.

// File: rtl/tcc_pkg.sv
package tcc_pkg;
  // control -> datapath strobes
  typedef struct packed {
    logic load;
    logic dec;
  } tccStrobes_t;
endpackage

// File: rtl/tcc_ctrl.sv
module tcc_ctrl
  import tcc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        frameStart,
  input  logic        charWr,
  input  logic        limitZero,
  input  logic        countAtOne,
  output tccStrobes_t strobes,
  output logic        active,
  output logic        frameComplete,
  output logic        lastChar
);
  always_comb begin
    strobes.load = frameStart;
    strobes.dec  = charWr && active && !frameStart;
    lastChar     = strobes.dec && countAtOne;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active        <= 1'b0;
      frameComplete <= 1'b0;
    end else if (frameStart) begin
      active        <= !limitZero;
      frameComplete <= 1'b0;
    end else if (lastChar) begin
      active        <= 1'b0;
      frameComplete <= 1'b1;
    end
  end
endmodule

// File: rtl/tcc_datapath.sv
module tcc_datapath
  import tcc_pkg::*;
#(
  parameter int W = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        limitWrEn,
  input  logic [W-1:0] limitWrData,
  input  tccStrobes_t strobes,
  output logic [W-1:0] limitQ,
  output logic [W-1:0] count,
  output logic        limitZero,
  output logic        countAtOne
);
  localparam logic [W-1:0] One = W'(1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      limitQ <= '0;
      count  <= '0;
    end else begin
      if (limitWrEn) limitQ <= limitWrData;
      if (strobes.load)     count <= limitQ;
      else if (strobes.dec) count <= count - One;
    end
  end

  assign limitZero  = (limitQ == '0);
  assign countAtOne = (count == One);
endmodule

// File: rtl/tx_char_counter.sv
module tx_char_counter
  import tcc_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         limitWrEn,
  input  logic [W-1:0] limitWrData,
  input  logic         frameStart,
  input  logic         charWr,
  output logic [W-1:0] limitQ,
  output logic [W-1:0] count,
  output logic         active,
  output logic         lastChar,
  output logic         frameComplete
);
  tccStrobes_t strobes;
  logic limitZero, countAtOne;

  tcc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .charWr(charWr),
    .limitZero(limitZero), .countAtOne(countAtOne), .strobes(strobes),
    .active(active), .frameComplete(frameComplete), .lastChar(lastChar)
  );

  tcc_datapath #(.W(W)) u_dp (
    .clk(clk), .rstN(rstN), .limitWrEn(limitWrEn), .limitWrData(limitWrData),
    .strobes(strobes), .limitQ(limitQ), .count(count),
    .limitZero(limitZero), .countAtOne(countAtOne)
  );
endmodule

// File: rtl/tcc_chk.sv
module tcc_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rstN,
  input logic         frameStart,
  input logic         charWr,
  input logic [W-1:0] limitQ,
  input logic [W-1:0] count,
  input logic         active,
  input logic         lastChar,
  input logic         frameComplete
);
  // R3
  load_val_chk: assert property (@(posedge clk) disable iff (!rstN)
    (frameStart && limitQ != '0) |=> (active && !frameComplete && count == $past(limitQ)));
  // R4
  zero_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (frameStart && limitQ == '0) |=> (!active && count == '0));
  // R5
  dec_one_chk: assert property (@(posedge clk) disable iff (!rstN)
    (active && charWr && !frameStart) |=> (count == $past(count) - W'(1)));
  // R6
  last_tag_chk: assert property (@(posedge clk) disable iff (!rstN)
    lastChar |-> (active && charWr && count == W'(1)));
  // R7
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!active && !frameStart) |=> $stable(count));
  // R7
  active_nz_chk: assert property (@(posedge clk) disable iff (!rstN)
    active |-> (count != '0));
  // R9
  done_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (frameComplete && !frameStart) |=> frameComplete);
  // R9
  done_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    lastChar |=> (frameComplete && !active));
endmodule

bind tx_char_counter tcc_chk #(.W(W)) u_chk (
  .clk(clk), .rstN(rstN), .frameStart(frameStart), .charWr(charWr),
  .limitQ(limitQ), .count(count), .active(active), .lastChar(lastChar),
  .frameComplete(frameComplete)
);

// File: tb/sim_tx_char_counter.sv
`timescale 1ns/1ps
module sim_tx_char_counter;
  localparam int W = 16;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic limitWrEn = 1'b0;
  logic [W-1:0] limitWrData = '0;
  logic frameStart = 1'b0;
  logic charWr = 1'b0;
  logic [W-1:0] limitQ, count;
  logic active, lastChar, frameComplete;

  int nTests = 0;
  int nFail = 0;
  bit finished = 1'b0;

  // bench model
  int mLim = 0, mCnt = 0;
  bit mAct = 1'b0, mDone = 1'b0;

  always #2.5 clk = ~clk;

  tx_char_counter #(.W(W)) u0 (
    .clk(clk), .rstN(rstN), .limitWrEn(limitWrEn), .limitWrData(limitWrData),
    .frameStart(frameStart), .charWr(charWr), .limitQ(limitQ), .count(count),
    .active(active), .lastChar(lastChar), .frameComplete(frameComplete)
  );

  task automatic chk(input string req, input int act, input int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // one cycle: drive at negedge, check lastChar before edge, then state after
  task automatic step(input bit wr, input int d, input bit fs, input bit cw,
                      input string req);
    bit expLast;
    @(negedge clk);
    limitWrEn = wr; limitWrData = W'(d); frameStart = fs; charWr = cw;
    #1;
    expLast = cw && mAct && !fs && (mCnt == 1);
    chk({req, " R6 lastChar"}, int'(lastChar), int'(expLast));
    if (fs) begin
      mCnt = mLim; mAct = (mLim != 0); mDone = 1'b0;
    end else if (cw && mAct) begin
      mCnt = mCnt - 1;
      if (mCnt == 0) begin mAct = 1'b0; mDone = 1'b1; end
    end
    if (wr) mLim = d;
    @(posedge clk); #1;
    chk({req, " count"}, int'(count), mCnt);
    chk({req, " active"}, int'(active), int'(mAct));
    chk({req, " R9 frameComplete"}, int'(frameComplete), int'(mDone));
    chk({req, " R2 limitQ"}, int'(limitQ), mLim);
  endtask

  initial begin
    #900000;
    if (!finished) begin
      nTests++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 count", int'(count), 0);
    chk("R1 limitQ", int'(limitQ), 0);
    chk("R1 active", int'(active), 0);
    chk("R1 frameComplete", int'(frameComplete), 0);
    chk("R1 lastChar", int'(lastChar), 0);
    @(negedge clk); rstN = 1'b1;

    // R4: zero limit disables; chars ignored
    step(0, 0, 1, 0, "R4 start0");
    for (int i = 0; i < 4; i++) step(0, 0, 0, 1, "R4 ignore");

    // R5 R6 R7 R9: sweep lengths with several gap patterns
    for (int pat = 0; pat < 3; pat++) begin
      for (int len = 1; len <= 40; len++) begin
        step(1, len, 0, 0, "R2 write");
        step(0, 0, 1, 0, "R3 load");
        for (int i = 0; i < len + 3; i++) begin
          step(0, 0, 0, 1, "R5 R7 char");
          if (pat == 1 && (i % 2 == 0)) step(0, 0, 0, 0, "R5 gap");
          if (pat == 2 && (i % 3 == 1)) step(0, 0, 0, 0, "R5 gap");
        end
        step(0, 0, 0, 0, "R9 hold");
      end
    end

    // R3: new limit queued mid-frame, not used until next start
    step(1, 10, 0, 0, "R2 write");
    step(0, 0, 1, 0, "R3 load");
    step(0, 0, 0, 1, "R5 char");
    step(1, 3, 0, 1, "R2 mid write");
    for (int i = 0; i < 9; i++) step(0, 0, 0, 1, "R7 char");
    step(0, 0, 1, 0, "R3 reload queued");
    for (int i = 0; i < 4; i++) step(0, 0, 0, 1, "R7 char");

    // R3: write in same cycle as frameStart uses the old limit
    step(1, 7, 1, 0, "R3 same-cycle write");
    step(0, 0, 0, 1, "R5 char");

    // R8: frameStart with charWr, reload wins
    step(0, 0, 0, 1, "R5 char");
    step(0, 0, 1, 1, "R8 start+char");
    step(0, 0, 0, 1, "R5 char");

    // R8 from finished state
    for (int i = 0; i < 8; i++) step(0, 0, 0, 1, "R7 drain");
    step(0, 0, 1, 1, "R8 restart+char");

    // R4: zero limit after an active frame
    step(1, 0, 0, 1, "R2 write0");
    step(0, 0, 1, 0, "R4 start0");
    step(0, 0, 0, 1, "R4 ignore");

    // full-range frame, one char per cycle
    step(1, 65535, 0, 0, "R2 writemax");
    step(0, 0, 1, 0, "R3 loadmax");
    for (int i = 0; i < 65537; i++) step(0, 0, 0, 1, "R5 R7 max");
    step(0, 0, 0, 0, "R9 hold");

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule